// File: doc/BRIEF.md
# Virtual MAC to Context CAM

This block sits at the front of a forwarding pipeline that is shared by several virtual routers. Each received frame presents its destination MAC address on the lookup port. The block compares that address against a small associative table. Every table slot binds one virtual MAC address to a 3-bit environment identifier.

A match sends the identifier downstream, where it selects the per-environment forwarding context. No match marks the frame for discard. A lookup can be issued on every cycle, and each result comes back exactly one cycle after its request.

A privileged management port installs, removes and reads back table slots. The block keeps a running count of how many MAC addresses each environment owns. It refuses any write that would give an environment more than its quota, and flags the refusal. Deleting every slot of an environment withdraws that environment's fast-path access, since its frames then miss.

Top module: `vmac_ctx_cam`

## Requirements
- R1: After reset the table holds no live slot, so every lookup reports a miss with the drop flag set.
- R2: A write (op code 2'b01) stores the MAC and environment ID at slot `mg_idx` and marks it live. A later lookup of that MAC reports a hit carrying that environment ID.
- R3: `res_valid` is high exactly one cycle after each cycle with `lk_valid` high, and lookups may be issued back to back. On a result, exactly one of `res_hit` and `res_drop` is high: drop means miss. Both are low when `res_valid` is low.
- R4: An invalidate (op code 2'b10) clears the live bit of slot `mg_idx`. Later lookups no longer match that slot.
- R5: When several live slots hold the same MAC, the lowest-numbered one supplies the environment ID.
- R6: A lookup issued in the same cycle as a management write sees the table as it was before that write. The next lookup sees the updated table.
- R7: Each environment may own at most 4 live slots. A write that would make a fifth is refused: the table and the counts stay unchanged, and `mg_err` pulses one cycle after the write.
- R8: Rewriting a slot that the same environment already owns is accepted even at the quota. Moving a slot to another environment frees one place in the old environment's quota.
- R9: A read (op code 2'b11) returns, one cycle later with `mg_rd_valid`, three things: the slot's MAC, its environment ID and its live bit, plus the live-slot count of the environment named on `mg_ve`.
- R10: With `mg_en` low, or with op code 2'b00, the management port changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_mac | input | 48 | Destination MAC to look up |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Lookup matched a live slot |
| res_ve | output | 3 | Environment ID of the matching slot (0 on miss) |
| res_drop | output | 1 | Frame is to be discarded |
| mg_en | input | 1 | Management command strobe |
| mg_op | input | 2 | 00 none, 01 write, 10 invalidate, 11 read |
| mg_idx | input | 5 | Slot number addressed |
| mg_mac | input | 48 | MAC for a write |
| mg_ve | input | 3 | Environment ID for a write, or count selector for a read |
| mg_err | output | 1 | Pulse: previous write refused by the quota |
| mg_rd_valid | output | 1 | Read data valid |
| mg_rd_mac | output | 48 | MAC of the slot read |
| mg_rd_ve | output | 3 | Environment ID of the slot read |
| mg_rd_live | output | 1 | Live bit of the slot read |
| mg_rd_cnt | output | 3 | Live-slot count of the selected environment |

## Verification
Every result of this block lands exactly one cycle after its request: lookup results, read data and the refusal pulse. The bench drives inputs on the falling edge and samples on the next falling edge, which falls after the single capturing rising edge. The lookup driver pushes each expected result into a queue as it issues the request. A monitor pops the queue on every falling edge on which `res_valid` is high, so back-to-back and same-cycle cases line up by construction. A result with nothing queued, or a queue left non-empty at the end, counts as a failure.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    parameter int MAC_W = 48;
    parameter int VE_W  = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_INVAL = 2'b10,
        OP_READ  = 2'b11
    } mg_op_e;

    typedef struct packed {
        logic             live;
        logic [VE_W-1:0]  ve;
        logic [MAC_W-1:0] mac;
    } cam_entry_t;
endpackage

// File: rtl/vmac_table.sv
module vmac_table
    import vmac_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       clr_en,
    input  logic [$clog2(ENTRIES)-1:0] idx,
    input  logic [MAC_W-1:0]           wr_mac,
    input  logic [VE_W-1:0]            wr_ve,
    output cam_entry_t [ENTRIES-1:0]   ent_o
);
    typedef struct packed {
        cam_entry_t [ENTRIES-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[idx].live = 1'b1;
            st_d.ent[idx].ve   = wr_ve;
            st_d.ent[idx].mac  = wr_mac;
        end else if (clr_en) begin
            st_d.ent[idx].live = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_o = st_q.ent;
endmodule

// File: rtl/vmac_match.sv
module vmac_match
    import vmac_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  cam_entry_t [ENTRIES-1:0] ent,
    input  logic [MAC_W-1:0]         key,
    output logic                     hit,
    output logic [VE_W-1:0]          ve
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = ent[g].live && (ent[g].mac == key);
    end

    // Scan from the top so the lowest matching slot is written last.
    always_comb begin
        hit = |eq;
        ve  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) ve = ent[i].ve;
        end
    end
endmodule

// File: rtl/vmac_quota.sv
module vmac_quota
    import vmac_pkg::*;
#(
    parameter int NUM_VE     = 8,
    parameter int MAX_PER_VE = 4,
    parameter int CNT_W      = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_req,
    input  logic                           inval_req,
    input  logic                           old_live,
    input  logic [VE_W-1:0]                old_ve,
    input  logic [VE_W-1:0]                new_ve,
    output logic                           accept,
    output logic [NUM_VE-1:0][CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PER_VE);

    typedef struct packed {
        logic [NUM_VE-1:0][CNT_W-1:0] cnt;
    } quota_state_t;

    quota_state_t st_d, st_q;
    logic same_owner, wr_ok, inc, dec;

    always_comb begin
        same_owner = old_live && (old_ve == new_ve);
        accept     = (st_q.cnt[new_ve] < CAP) || same_owner;
        wr_ok      = wr_req && accept;
        st_d       = st_q;
        inc        = 1'b0;
        dec        = 1'b0;
        for (int v = 0; v < NUM_VE; v++) begin
            inc = wr_ok && (new_ve == VE_W'(v));
            dec = (wr_ok || inval_req) && old_live && (old_ve == VE_W'(v));
            if (inc && !dec)      st_d.cnt[v] = st_q.cnt[v] + CNT_W'(1);
            else if (dec && !inc) st_d.cnt[v] = st_q.cnt[v] - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/vmac_ctx_cam.sv
module vmac_ctx_cam
    import vmac_pkg::*;
#(
    parameter int ENTRIES    = 32,
    parameter int MAX_PER_VE = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               lk_valid,
    input  logic [MAC_W-1:0]                   lk_mac,
    output logic                               res_valid,
    output logic                               res_hit,
    output logic [VE_W-1:0]                    res_ve,
    output logic                               res_drop,
    input  logic                               mg_en,
    input  logic [1:0]                         mg_op,
    input  logic [$clog2(ENTRIES)-1:0]         mg_idx,
    input  logic [MAC_W-1:0]                   mg_mac,
    input  logic [VE_W-1:0]                    mg_ve,
    output logic                               mg_err,
    output logic                               mg_rd_valid,
    output logic [MAC_W-1:0]                   mg_rd_mac,
    output logic [VE_W-1:0]                    mg_rd_ve,
    output logic                               mg_rd_live,
    output logic [$clog2(MAX_PER_VE+1)-1:0]    mg_rd_cnt
);
    localparam int NUM_VE = 1 << VE_W;
    localparam int CNT_W  = $clog2(MAX_PER_VE + 1);

    typedef struct packed {
        logic             res_valid;
        logic             res_hit;
        logic             res_drop;
        logic [VE_W-1:0]  res_ve;
        logic             err;
        logic             rd_valid;
        logic             rd_live;
        logic [VE_W-1:0]  rd_ve;
        logic [MAC_W-1:0] rd_mac;
        logic [CNT_W-1:0] rd_cnt;
    } top_state_t;

    top_state_t st_d, st_q;

    cam_entry_t [ENTRIES-1:0]      ent;
    cam_entry_t                    old_ent;
    logic [NUM_VE-1:0][CNT_W-1:0]  quota_cnt;
    logic                          m_hit, accept;
    logic [VE_W-1:0]               m_ve;
    logic                          wr_req, inval_req, rd_req;
    mg_op_e                        op;

    assign op        = mg_op_e'(mg_op);
    assign wr_req    = mg_en && (op == OP_WRITE);
    assign inval_req = mg_en && (op == OP_INVAL);
    assign rd_req    = mg_en && (op == OP_READ);
    assign old_ent   = ent[mg_idx];

    vmac_table #(.ENTRIES(ENTRIES)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_req && accept),
        .clr_en (inval_req),
        .idx    (mg_idx),
        .wr_mac (mg_mac),
        .wr_ve  (mg_ve),
        .ent_o  (ent)
    );

    vmac_match #(.ENTRIES(ENTRIES)) u_match (
        .ent (ent),
        .key (lk_mac),
        .hit (m_hit),
        .ve  (m_ve)
    );

    vmac_quota #(
        .NUM_VE     (NUM_VE),
        .MAX_PER_VE (MAX_PER_VE),
        .CNT_W      (CNT_W)
    ) u_quota (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .inval_req (inval_req),
        .old_live  (old_ent.live),
        .old_ve    (old_ent.ve),
        .new_ve    (mg_ve),
        .accept    (accept),
        .cnt_o     (quota_cnt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = lk_valid;
        st_d.res_hit   = lk_valid && m_hit;
        st_d.res_drop  = lk_valid && !m_hit;
        st_d.res_ve    = (lk_valid && m_hit) ? m_ve : '0;
        st_d.err       = wr_req && !accept;
        st_d.rd_valid  = rd_req;
        if (rd_req) begin
            st_d.rd_live = old_ent.live;
            st_d.rd_ve   = old_ent.ve;
            st_d.rd_mac  = old_ent.mac;
            st_d.rd_cnt  = quota_cnt[mg_ve];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid   = st_q.res_valid;
    assign res_hit     = st_q.res_hit;
    assign res_ve      = st_q.res_ve;
    assign res_drop    = st_q.res_drop;
    assign mg_err      = st_q.err;
    assign mg_rd_valid = st_q.rd_valid;
    assign mg_rd_mac   = st_q.rd_mac;
    assign mg_rd_ve    = st_q.rd_ve;
    assign mg_rd_live  = st_q.rd_live;
    assign mg_rd_cnt   = st_q.rd_cnt;
endmodule

// File: rtl/vmac_ctx_cam_chk.sv
module vmac_ctx_cam_chk #(
    parameter int NUM_VE     = 8,
    parameter int MAX_PER_VE = 4,
    parameter int CNT_W      = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          lk_valid,
    input logic                          res_valid,
    input logic                          res_hit,
    input logic                          res_drop,
    input logic                          mg_en,
    input logic [1:0]                    mg_op,
    input logic                          mg_err,
    input logic                          mg_rd_valid,
    input logic [NUM_VE-1:0][CNT_W-1:0]  cnt
);
    // R3
    res_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    // R3
    res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    // R3
    hit_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_drop));
    // R3
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_drop));
    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mg_err |-> $past(mg_en && (mg_op == 2'b01)));
    // R9
    rd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_en && (mg_op == 2'b11)) |=> mg_rd_valid);
    // R10
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mg_en |=> (!mg_rd_valid && !mg_err));

    always @(posedge clk) begin
        if (rst_n) begin
            for (int v = 0; v < NUM_VE; v++) begin
                // R7
                quota_cap_chk: assert (cnt[v] <= CNT_W'(MAX_PER_VE))
                    else $error("quota exceeded for environment %0d", v);
            end
        end
    end
endmodule

bind vmac_ctx_cam vmac_ctx_cam_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_drop    (res_drop),
    .mg_en       (mg_en),
    .mg_op       (mg_op),
    .mg_err      (mg_err),
    .mg_rd_valid (mg_rd_valid),
    .cnt         (quota_cnt)
);

// File: tb/vmac_ctx_cam_bench.sv
module vmac_ctx_cam_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_mac = '0;
    logic        res_valid, res_hit, res_drop;
    logic [2:0]  res_ve;
    logic        mg_en = 1'b0;
    logic [1:0]  mg_op = 2'b00;
    logic [4:0]  mg_idx = '0;
    logic [47:0] mg_mac = '0;
    logic [2:0]  mg_ve = '0;
    logic        mg_err, mg_rd_valid, mg_rd_live;
    logic [47:0] mg_rd_mac;
    logic [2:0]  mg_rd_ve, mg_rd_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    vmac_ctx_cam u_vmac_ctx_cam (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_mac(lk_mac),
        .res_valid(res_valid), .res_hit(res_hit), .res_ve(res_ve), .res_drop(res_drop),
        .mg_en(mg_en), .mg_op(mg_op), .mg_idx(mg_idx), .mg_mac(mg_mac), .mg_ve(mg_ve),
        .mg_err(mg_err), .mg_rd_valid(mg_rd_valid), .mg_rd_mac(mg_rd_mac),
        .mg_rd_ve(mg_rd_ve), .mg_rd_live(mg_rd_live), .mg_rd_cnt(mg_rd_cnt)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: one lookup per call, back to back when called consecutively.
    task automatic lookup(input logic [47:0] mac, input bit hit,
                          input logic [2:0] ve, input string tag);
        lk_valid = 1'b1;
        lk_mac   = mac;
        exp_q.push_back({hit, ve});
        tag_q.push_back(tag);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic mg_write(input logic [4:0] idx, input logic [47:0] mac,
                            input logic [2:0] ve, input bit exp_err, input string tag);
        mg_en = 1'b1; mg_op = 2'b01; mg_idx = idx; mg_mac = mac; mg_ve = ve;
        @(negedge clk);
        mg_en = 1'b0; mg_op = 2'b00;
        chk(mg_err == exp_err, tag, "mg_err after write", 64'(mg_err), 64'(exp_err));
    endtask

    task automatic mg_inval(input logic [4:0] idx);
        mg_en = 1'b1; mg_op = 2'b10; mg_idx = idx;
        @(negedge clk);
        mg_en = 1'b0; mg_op = 2'b00;
    endtask

    task automatic mg_read(input logic [4:0] idx, input logic [2:0] sel,
                           input bit live, input logic [47:0] mac, input logic [2:0] ve,
                           input logic [2:0] cnt, input string tag);
        mg_en = 1'b1; mg_op = 2'b11; mg_idx = idx; mg_ve = sel;
        @(negedge clk);
        mg_en = 1'b0; mg_op = 2'b00;
        chk(mg_rd_valid == 1'b1, tag, "mg_rd_valid", 64'(mg_rd_valid), 64'd1);
        chk(mg_rd_live == live, tag, "mg_rd_live", 64'(mg_rd_live), 64'(live));
        chk(mg_rd_cnt == cnt, tag, "mg_rd_cnt", 64'(mg_rd_cnt), 64'(cnt));
        if (live) begin
            chk(mg_rd_mac == mac, tag, "mg_rd_mac", 64'(mg_rd_mac), 64'(mac));
            chk(mg_rd_ve == ve, tag, "mg_rd_ve", 64'(mg_rd_ve), 64'(ve));
        end
    endtask

    // Monitor: pops one expected item per result.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected res_valid", 64'd1, 64'd0);
            end else begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(res_hit == e[3] && res_drop == !e[3] && (!e[3] || res_ve == e[2:0]),
                    t, "lookup {hit,drop,ve}",
                    64'({res_hit, res_drop, res_ve}), 64'({e[3], !e[3], e[2:0]}));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 64'd0, 64'd1);
        finish_run();
    end

    localparam logic [47:0] MAC_A = 48'h02_00_00_00_00_0A;
    localparam logic [47:0] MAC_B = 48'h02_00_00_00_00_0B;
    localparam logic [47:0] MAC_C = 48'h02_00_00_00_00_0C;
    localparam logic [47:0] MAC_D = 48'h02_00_00_00_00_0D;
    localparam logic [47:0] MAC_E = 48'h02_00_00_00_0E_00;
    localparam logic [47:0] MAC_F = 48'h02_00_00_00_00_0F;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        chk(!res_valid && !mg_err && !mg_rd_valid, "R1", "outputs after reset",
            64'({res_valid, mg_err, mg_rd_valid}), 64'd0);
        lookup(MAC_A, 1'b0, 3'd0, "R1");
        lookup(48'h0, 1'b0, 3'd0, "R1");

        // R2: install and hit
        mg_write(5'd3, MAC_A, 3'd2, 1'b0, "R2");
        lookup(MAC_A, 1'b1, 3'd2, "R2");
        // R3: back-to-back mixed hit and miss
        lookup(MAC_B, 1'b0, 3'd0, "R3");
        lookup(MAC_A, 1'b1, 3'd2, "R3");
        lookup(MAC_B, 1'b0, 3'd0, "R3");
        @(negedge clk);

        // R5: duplicate MAC, lowest slot wins
        mg_write(5'd7, MAC_C, 3'd6, 1'b0, "R5");
        mg_write(5'd1, MAC_C, 3'd5, 1'b0, "R5");
        lookup(MAC_C, 1'b1, 3'd5, "R5");
        // R4: invalidation removes slots one by one
        mg_inval(5'd1);
        lookup(MAC_C, 1'b1, 3'd6, "R4");
        mg_inval(5'd7);
        lookup(MAC_C, 1'b0, 3'd0, "R4");
        mg_read(5'd1, 3'd5, 1'b0, 48'h0, 3'd0, 3'd0, "R4");

        // R6: write and lookup in the same cycle
        lk_valid = 1'b1; lk_mac = MAC_D;
        exp_q.push_back({1'b0, 3'd0}); tag_q.push_back("R6");
        mg_en = 1'b1; mg_op = 2'b01; mg_idx = 5'd10; mg_mac = MAC_D; mg_ve = 3'd1;
        @(negedge clk);
        lk_valid = 1'b0; mg_en = 1'b0; mg_op = 2'b00;
        lookup(MAC_D, 1'b1, 3'd1, "R6");

        // R7: quota of four per environment
        for (int i = 0; i < 4; i++)
            mg_write(5'(20 + i), MAC_E + 48'(i), 3'd4, 1'b0, "R7");
        mg_write(5'd24, MAC_E + 48'd4, 3'd4, 1'b1, "R7");
        lookup(MAC_E + 48'd4, 1'b0, 3'd0, "R7");
        mg_read(5'd24, 3'd4, 1'b0, 48'h0, 3'd0, 3'd4, "R7");
        @(negedge clk);
        chk(!mg_err, "R7", "mg_err is a single pulse", 64'(mg_err), 64'd0);

        // R8: rewrite by owner at quota, then move a slot away
        mg_write(5'd21, MAC_F, 3'd4, 1'b0, "R8");
        lookup(MAC_F, 1'b1, 3'd4, "R8");
        lookup(MAC_E + 48'd1, 1'b0, 3'd0, "R8");
        mg_write(5'd22, MAC_E + 48'd2, 3'd0, 1'b0, "R8");
        mg_write(5'd24, MAC_E + 48'd4, 3'd4, 1'b0, "R8");
        lookup(MAC_E + 48'd4, 1'b1, 3'd4, "R8");
        mg_read(5'd22, 3'd4, 1'b1, MAC_E + 48'd2, 3'd0, 3'd4, "R8");

        // R9: readback of a slot and a count
        mg_read(5'd3, 3'd2, 1'b1, MAC_A, 3'd2, 3'd1, "R9");

        // R10: disabled or no-op commands change nothing
        mg_en = 1'b0; mg_op = 2'b01; mg_idx = 5'd30; mg_mac = MAC_B; mg_ve = 3'd7;
        @(negedge clk);
        chk(!mg_rd_valid && !mg_err, "R10", "no response when disabled",
            64'({mg_rd_valid, mg_err}), 64'd0);
        mg_en = 1'b1; mg_op = 2'b00;
        @(negedge clk);
        mg_en = 1'b0;
        chk(!mg_rd_valid && !mg_err, "R10", "no response to op 00",
            64'({mg_rd_valid, mg_err}), 64'd0);
        lookup(MAC_B, 1'b0, 3'd0, "R10");
        mg_read(5'd30, 3'd7, 1'b0, 48'h0, 3'd0, 3'd0, "R10");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "results outstanding at end",
            64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule